// File: doc/BRIEF.md
# Sampled Fault Input Qualifier

This block cleans up one asynchronous fault pin before it reaches power-stage shutdown logic. The pin is first brought into the bus clock domain. A prescaler then produces a sample tick at a spacing set by software. A change of level is accepted only after the same new level has been seen on a programmed number of back-to-back ticks. Assertion and release are filtered the same way. The accepted level sets a sticky fault flag, which software clears with a strobe once the fault has gone away.

The nominal filter time is (count + 3) × period bus clocks. Tick phase is free-running relative to the pin, so a pulse up to one sample period shorter than nominal can still be accepted. A period of zero turns the filter into a plain synchronizer. There is no data stream here: every pin is a plain control or status level. Writes to the configuration take effect through a one-cycle load strobe, and that strobe also restarts the sampling.

Top module: `fault_qual_filter`

## Requirements
- R1: On `cfg_wr`, `cfg_word` is captured. Bits 7:0 give the sample period P, the number of bus clocks between ticks. Bits 10:8 give the count field C. Bits 15:11 have no effect. After reset the captured word is zero.
- R2: The number of consecutive agreeing ticks needed to accept a new level is N = C + 3, so C = 7 needs 10 ticks.
- R3: The pin passes through a two-flop synchronizer and is examined only on ticks. With `cfg_wr` taken at edge 0 and the pin high from edge L for H edges, ticks fall on edges that are multiples of P. `fault_filt` rises after edge T0 + (N-1)·P, where T0 is the first multiple of P that is at least L+2. This happens only if that edge is at most L+H+1; otherwise the output never rises.
- R4: Any tick that sees the current output level clears the pending count. The high-to-low transition is qualified by the same N-tick rule.
- R5: With P = 0 the filter is bypassed, and `fault_filt` follows the pin two edges after it changes.
- R6: `cfg_wr` restarts both the prescaler and the pending count. The first tick after a write falls P edges after it.
- R7: `fault_flag` is set on the edge after `fault_filt` is high. It stays set until it is cleared.
- R8: `flag_clr` clears `fault_flag` only while `fault_filt` is low. A clear while the filtered fault is active has no effect.
- R9: While reset is held, `fault_filt` and `fault_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_raw | input | 1 | Asynchronous fault pin, active high |
| cfg_word | input | 16 | Filter configuration: period in 7:0, count in 10:8 |
| cfg_wr | input | 1 | One-cycle load strobe for `cfg_word`; restarts sampling |
| flag_clr | input | 1 | Request to clear the sticky flag |
| fault_filt | output | 1 | Qualified fault level |
| fault_flag | output | 1 | Sticky fault flag |

## Verification
Each pulse starts with a configuration load at a known edge, so the result edge is fixed. It is two synchronizer edges plus the tick alignment plus (N-1) further ticks, as given in R3. The bench counts observations from that load edge. It samples on falling edges and checks that the rise appears at exactly the computed edge and not before. The flag is due one edge after the rise. Clears are checked on the falling edge after the strobe edge. One vector delays the pulse against the tick phase, so that a pulse about 10% shorter than nominal is expected to pass.

// File: rtl/fq_pkg.sv
package fq_pkg;
  localparam int FQ_CFG_W  = 16;
  localparam int FQ_PER_W  = 8;
  localparam int FQ_CNT_W  = 3;
  localparam int FQ_OFFSET = 3;

  typedef struct packed {
    logic [FQ_CNT_W-1:0] cnt;
    logic [FQ_PER_W-1:0] per;
  } fq_cfg_t;

  function automatic fq_cfg_t fq_decode(input logic [FQ_CFG_W-1:0] w);
    fq_cfg_t c;
    c.per = w[FQ_PER_W-1:0];
    c.cnt = w[FQ_PER_W+FQ_CNT_W-1:FQ_PER_W];
    return c;
  endfunction
endpackage

// File: rtl/fq_sync.sv
module fq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= din;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/fq_tick.sv
module fq_tick #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PER_W-1:0] cnt_q;
  logic [PER_W-1:0] last;

  assign last = PER_W'(period - 1'b1);
  assign tick = (period != '0) && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (!rst_n || restart || period == '0) cnt_q <= '0;
    else if (cnt_q == last) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fq_qual.sv
module fq_qual #(
  parameter int NEED_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bypass,
  input  logic              tick,
  input  logic              sample,
  input  logic [NEED_W-1:0] need,
  output logic              level,
  output logic [NEED_W-1:0] run_cnt
);
  logic [NEED_W-1:0] nxt;
  assign nxt = run_cnt + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level   <= 1'b0;
      run_cnt <= '0;
    end else if (bypass) begin
      level   <= sample;
      run_cnt <= '0;
    end else if (restart) begin
      run_cnt <= '0;
    end else if (tick) begin
      if (sample == level) begin
        run_cnt <= '0;
      end else if (nxt >= need) begin
        level   <= sample;
        run_cnt <= '0;
      end else begin
        run_cnt <= nxt;
      end
    end
  end
endmodule

// File: rtl/fq_flag.sv
module fq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else if (active) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/fault_qual_filter.sv
module fault_qual_filter
  import fq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NEED_OFFSET = FQ_OFFSET
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fault_raw,
  input  logic [FQ_CFG_W-1:0] cfg_word,
  input  logic                cfg_wr,
  input  logic                flag_clr,
  output logic                fault_filt,
  output logic                fault_flag
);
  localparam int MAX_NEED = (1 << FQ_CNT_W) - 1 + NEED_OFFSET;
  localparam int NEED_W   = $clog2(MAX_NEED + 1);

  fq_cfg_t           cfg_q;
  logic              pin_s;
  logic              tick;
  logic              bypass;
  logic [NEED_W-1:0] need;
  logic [NEED_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) cfg_q <= fq_decode(cfg_word);
  end

  assign bypass = (cfg_q.per == '0);
  assign need   = NEED_W'(cfg_q.cnt) + NEED_W'(NEED_OFFSET);

  fq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(fault_raw), .dout(pin_s)
  );

  fq_tick #(.PER_W(FQ_PER_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .period(cfg_q.per), .tick(tick)
  );

  fq_qual #(.NEED_W(NEED_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .restart(cfg_wr), .bypass(bypass), .tick(tick),
    .sample(pin_s), .need(need), .level(fault_filt), .run_cnt(run_cnt)
  );

  fq_flag u_flag (
    .clk(clk), .rst_n(rst_n), .active(fault_filt), .clr(flag_clr), .flag(fault_flag)
  );
endmodule

// File: rtl/fq_checker.sv
module fq_checker #(
  parameter int NEED_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bypass,
  input logic              cfg_wr,
  input logic              flag_clr,
  input logic              fault_filt,
  input logic              fault_flag,
  input logic [NEED_W-1:0] run_cnt,
  input logic [NEED_W-1:0] need
);
  a_r3_change_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fault_filt) |-> $past(tick || bypass));

  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt < need);

  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> run_cnt == '0);

  a_r7_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fault_filt |=> fault_flag);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fault_flag && !flag_clr |=> fault_flag);

  a_r8_clear_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !fault_filt |=> !fault_flag);
endmodule

bind fault_qual_filter fq_checker #(.NEED_W(NEED_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bypass(bypass), .cfg_wr(cfg_wr),
  .flag_clr(flag_clr), .fault_filt(fault_filt), .fault_flag(fault_flag),
  .run_cnt(run_cnt), .need(need)
);

// File: tb/tb_fault_qual_filter.sv
module tb_fault_qual_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fault_raw = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        cfg_wr = 1'b0;
  logic        flag_clr = 1'b0;
  logic        fault_filt, fault_flag;
  int          errors = 0;
  int          checks = 0;
  int          cyc = 0;

  always #2.5 clk = ~clk;

  fault_qual_filter dut (
    .clk(clk), .rst_n(rst_n), .fault_raw(fault_raw), .cfg_word(cfg_word),
    .cfg_wr(cfg_wr), .flag_clr(flag_clr), .fault_filt(fault_filt), .fault_flag(fault_flag)
  );

  // {cfg word, lead edges, hold edges}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {16'h0004, 16'd0,  16'd11},   // R3 exact minimum passes
    {16'h0004, 16'd0,  16'd10},   // R3 one short fails
    {16'h0713, 16'd0,  16'd189},  // R2 count 7 -> 10 ticks
    {16'h0713, 16'd17, 16'd172},  // R3 favourable phase, shorter pulse passes
    {16'h0713, 16'd0,  16'd172},  // R3 same pulse aligned fails
    {16'h0201, 16'd0,  16'd5},    // R2 period 1
    {16'h0201, 16'd0,  16'd4},
    {16'h0000, 16'd0,  16'd1},    // R5 bypass
    {16'hFB04, 16'd0,  16'd24},   // R1 bits 15:11 ignored
    {16'h0102, 16'd3,  16'd9}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic run_vec(input logic [47:0] v);
    int per, n, lead, hold, t0, rise, first_rise, first_flag;
    bit pass;
    per  = int'(v[39:32]);
    n    = int'(v[42:40]) + 3;
    lead = int'(v[31:16]);
    hold = int'(v[15:0]);
    if (per == 0) begin
      rise = lead + 2;
      pass = hold >= 1;
    end else begin
      t0   = ((lead + 2 + per - 1) / per) * per;
      rise = t0 + (n - 1) * per;
      pass = rise <= lead + hold + 1;
    end
    first_rise = -1;
    first_flag = -1;
    @(negedge clk);
    cfg_word  = v[47:32];
    cfg_wr    = 1'b1;
    fault_raw = (lead == 0);
    for (int i = 0; i < lead + hold + 8; i++) begin
      @(negedge clk);
      cfg_wr = 1'b0;
      if (fault_filt && first_rise < 0) first_rise = i;
      if (fault_flag && first_flag < 0) first_flag = i;
      fault_raw = (i + 1 >= lead) && (i + 1 < lead + hold);
    end
    if (pass) begin
      chk(first_rise == rise, "R3 rise edge", first_rise, rise);
      chk(first_flag == rise + 1, "R7 flag edge", first_flag, rise + 1);
    end else begin
      chk(first_rise == -1, "R3 short pulse rejected", first_rise, -1);
      chk(first_flag == -1, "R7 no flag", first_flag, -1);
    end
    repeat (260) @(negedge clk);
    chk(fault_filt == 1'b0, "R4 released", fault_filt, 0);
    chk(fault_flag == pass, "R7 sticky", fault_flag, pass);
    clear_flag();
    chk(fault_flag == 1'b0, "R8 clear idle", fault_flag, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(fault_filt == 1'b0, "R9 reset filt", fault_filt, 0);
    chk(fault_flag == 1'b0, "R9 reset flag", fault_flag, 0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VEC[k]);

    // R6: reload mid-count restarts the prescaler and the count
    begin
      int first_rise;
      first_rise = -1;
      @(negedge clk);
      cfg_word = 16'h0004; cfg_wr = 1'b1; fault_raw = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        cfg_wr = (i == 7);
        if (fault_filt && first_rise < 0) first_rise = i;
      end
      chk(first_rise == 20, "R6 restart delays rise", first_rise, 20);
    end

    // R8: clear while active ignored; R4: short low glitch held off
    clear_flag();
    chk(fault_flag == 1'b1, "R8 clear while active", fault_flag, 1);
    @(negedge clk); fault_raw = 1'b0;
    repeat (3) @(negedge clk);
    fault_raw = 1'b1;
    begin
      int lows;
      lows = 0;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        if (!fault_filt) lows++;
      end
      chk(lows == 0, "R4 release glitch filtered", lows, 0);
    end
    // R4: release takes N ticks; period 4, N=3 -> not low within 8 edges
    fault_raw = 1'b0;
    repeat (8) @(negedge clk);
    chk(fault_filt == 1'b1, "R4 release not early", fault_filt, 1);
    repeat (20) @(negedge clk);
    chk(fault_filt == 1'b0, "R4 release done", fault_filt, 0);
    chk(fault_flag == 1'b1, "R7 flag holds after release", fault_flag, 1);
    clear_flag();
    chk(fault_flag == 1'b0, "R8 clear after release", fault_flag, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule